// File: doc/BRIEF.md
# Peripheral Bus Select and Transfer Latch

This block sits on the host side of a peripheral card attached to a parallel calculator I/O bus. A static 4-bit select-code setting is compared with the 4-bit peripheral address that the host places on the bus. While the two agree, the card is selected. It then pulls its active-low presence flag and its active-low status line low, which tells the host the card is ready and has no error.

While the card is selected, each host I/O strobe is decoded once. The strobe is first synchronised to the local clock and edge-detected. The direction bit says whether the transfer runs host-to-card (write) or card-to-host (read).

- On a write, the 8-bit host data is captured into the output data register.
- On any selected strobe, the direction bit and the two command-code bits are captured into a command register, and a command-valid flag is raised for the downstream control logic.
- The control logic lowers that flag with a one-cycle acknowledge.
- On a read, the card drives its input-register value onto the bus while the strobe is held. It never drives the bus while the host runs an interrupt poll (interrupt line low).

Top module: `pbsel_front`

## Requirements
- R1: After reset: `flag_n` and `status_n` are 1, `out_data`, `cmd` and `cmd_valid` are 0, and `host_data_oe` is 0.
- R2: When `per_addr` equals `sel_code`, `flag_n` and `status_n` both go low one clock later and stay low while the match lasts.
- R3: When `per_addr` differs from `sel_code`, `flag_n` and `status_n` are high, and strobes change neither `out_data`, `cmd` nor `cmd_valid`.
- R4: A selected strobe with `to_card`=1 stores `host_data_i` into `out_data`.
- R5: Every selected strobe stores the command: `cmd[2]` = `to_card`, `cmd[1]` = `ic2`, `cmd[0]` = `ic1`.
- R6: While selected with `to_card`=0, `int_n`=1 and the synchronised strobe high, `host_data_oe` is 1 and `host_data_o` equals `card_rd_data`. Otherwise `host_data_o` is 0.
- R7: While `int_n` is 0, `host_data_oe` is 0 and `host_data_o` is 0.
- R8: One strobe pulse causes exactly one capture, however long it is held. After an acknowledge during a long pulse, `cmd_valid` stays 0.
- R9: `cmd_valid` rises on a capture and falls the cycle after `cmd_ack`. If a capture and `cmd_ack` fall in the same cycle, the capture wins.
- R10: A read strobe (`to_card`=0) leaves `out_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_code | input | 4 | Static select-code setting |
| per_addr | input | 4 | Peripheral address from host |
| io_strobe | input | 1 | Host I/O strobe, active high |
| to_card | input | 1 | Direction: 1 = host-to-card write, 0 = read |
| ic1 | input | 1 | Command code bit 1 |
| ic2 | input | 1 | Command code bit 2 |
| int_n | input | 1 | Low during an interrupt poll |
| host_data_i | input | 8 | Data bus as driven by host |
| host_data_o | output | 8 | Data the card drives to host |
| host_data_oe | output | 1 | Card drives the data bus |
| card_rd_data | input | 8 | Input-register value from control logic |
| flag_n | output | 1 | Presence/ready flag, active low |
| status_n | output | 1 | No-error status, active low |
| out_data | output | 8 | Output data register |
| cmd | output | 3 | Command register {to_card, ic2, ic1} |
| cmd_valid | output | 1 | New command waiting |
| cmd_ack | input | 1 | Acknowledge from control logic |

## Verification
The hardest case to reach from the ports is a capture landing in the same cycle as an acknowledge. The stimulus sets it up in three steps:
- It leaves one command unacknowledged.
- It raises the strobe and the acknowledge together. The acknowledge clears the old command at the first edge and is still high when the capture edge arrives two clocks later.
- It then checks that `cmd_valid` is set after that edge.

A second case that needs care is the long strobe with an acknowledge in the middle, which shows that a held strobe does not capture again.

// File: rtl/pbsel_pkg.sv
`timescale 1ns/1ps
package pbsel_pkg;
  localparam int CMD_W = 3;

  typedef struct packed {
    logic to_card;
    logic code_hi;
    logic code_lo;
  } pbsel_cmd_t;
endpackage

// File: rtl/pbsel_strobe_sync.sv
`timescale 1ns/1ps
module pbsel_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic level_o,
  output logic rise_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], strobe_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign level_o = chain_q[LAST-1];
  assign rise_o  = chain_q[LAST-1] & ~chain_q[LAST];
endmodule

// File: rtl/pbsel_addr_match.sv
`timescale 1ns/1ps
module pbsel_addr_match #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] code_i,
  output logic              sel_o
);
  logic sel_d;
  logic sel_q;

  always_comb begin
    sel_d = (addr_i == code_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/pbsel_xfer_latch.sv
`timescale 1ns/1ps
module pbsel_xfer_latch
  import pbsel_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic              to_card_i,
  input  logic              code_lo_i,
  input  logic              code_hi_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] out_data_o,
  output pbsel_cmd_t        cmd_o,
  output logic              cmd_valid_o
);
  logic [DATA_W-1:0] out_q, out_d;
  pbsel_cmd_t        cmd_q, cmd_d;
  logic              vld_q, vld_d;
  logic              out_en;
  logic              cmd_en;

  always_comb begin
    out_en = capture_i & to_card_i;
    cmd_en = capture_i;
    out_d  = out_q;
    cmd_d  = cmd_q;
    vld_d  = vld_q;
    if (ack_i)  vld_d = 1'b0;
    if (cmd_en) begin
      cmd_d.to_card = to_card_i;
      cmd_d.code_hi = code_hi_i;
      cmd_d.code_lo = code_lo_i;
      vld_d         = 1'b1;
    end
    if (out_en) out_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      cmd_q <= '0;
      vld_q <= 1'b0;
    end else begin
      out_q <= out_d;
      cmd_q <= cmd_d;
      vld_q <= vld_d;
    end
  end

  assign out_data_o  = out_q;
  assign cmd_o       = cmd_q;
  assign cmd_valid_o = vld_q;

  AST_CAPTURE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> cmd_valid_o); // R9
  AST_ACK_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !capture_i) |=> !cmd_valid_o); // R9
  AST_READ_KEEPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i && !to_card_i) |=> $stable(out_data_o)); // R10
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture_i && !cmd_valid_o) |=> !cmd_valid_o); // R8
endmodule

// File: rtl/pbsel_front.sv
`timescale 1ns/1ps
module pbsel_front
  import pbsel_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sel_code,
  input  logic [ADDR_W-1:0] per_addr,
  input  logic              io_strobe,
  input  logic              to_card,
  input  logic              ic1,
  input  logic              ic2,
  input  logic              int_n,
  input  logic [DATA_W-1:0] host_data_i,
  output logic [DATA_W-1:0] host_data_o,
  output logic              host_data_oe,
  input  logic [DATA_W-1:0] card_rd_data,
  output logic              flag_n,
  output logic              status_n,
  output logic [DATA_W-1:0] out_data,
  output logic [CMD_W-1:0]  cmd,
  output logic              cmd_valid,
  input  logic              cmd_ack
);
  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  logic        selected;
  logic        stb_level;
  logic        stb_rise;
  logic        capture;
  logic        drive_en;
  pbsel_cmd_t  cmd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pbsel_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .clk   (clk),
    .rst_n (rst_int_n),
    .addr_i(per_addr),
    .code_i(sel_code),
    .sel_o (selected)
  );

  pbsel_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .strobe_i(io_strobe),
    .level_o (stb_level),
    .rise_o  (stb_rise)
  );

  always_comb begin
    capture  = stb_rise & selected;
    drive_en = selected & ~to_card & int_n & stb_level;
  end

  pbsel_xfer_latch #(.DATA_W(DATA_W)) u_latch (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .capture_i  (capture),
    .to_card_i  (to_card),
    .code_lo_i  (ic1),
    .code_hi_i  (ic2),
    .data_i     (host_data_i),
    .ack_i      (cmd_ack),
    .out_data_o (out_data),
    .cmd_o      (cmd_s),
    .cmd_valid_o(cmd_valid)
  );

  assign cmd          = cmd_s;
  assign flag_n       = ~selected;
  assign status_n     = ~selected;
  assign host_data_oe = drive_en;
  assign host_data_o  = drive_en ? card_rd_data : '0;

  AST_UNSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    flag_n |=> ($stable(out_data) && $stable(cmd))); // R3
  AST_POLL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !int_n |-> (!host_data_oe && host_data_o == '0)); // R7
endmodule

// File: tb/pbsel_front_test.sv
`timescale 1ns/1ps
module pbsel_front_test;
  typedef struct packed {
    logic [7:0] data;
    logic [2:0] cmd;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] sel_code, per_addr;
  logic       io_strobe, to_card, ic1, ic2, int_n, cmd_ack;
  logic [7:0] host_data_i, card_rd_data;
  logic [7:0] host_data_o, out_data;
  logic       host_data_oe, flag_n, status_n, cmd_valid;
  logic [2:0] cmd;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;
  exp_t exp_q[$];
  logic prev_valid = 1'b0;

  always #10 clk = ~clk;

  pbsel_front uut (
    .clk(clk), .rst_n(rst_n), .sel_code(sel_code), .per_addr(per_addr),
    .io_strobe(io_strobe), .to_card(to_card), .ic1(ic1), .ic2(ic2),
    .int_n(int_n), .host_data_i(host_data_i), .host_data_o(host_data_o),
    .host_data_oe(host_data_oe), .card_rd_data(card_rd_data),
    .flag_n(flag_n), .status_n(status_n), .out_data(out_data), .cmd(cmd),
    .cmd_valid(cmd_valid), .cmd_ack(cmd_ack)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops an expected item each time cmd_valid rises
  always @(negedge clk) begin
    if (!done && rst_n) begin
      if (cmd_valid && !prev_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected capture", {29'd0, cmd}, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(out_data == e.data, "R4/R10 out_data", {24'd0, out_data}, {24'd0, e.data});
          check(cmd == e.cmd, "R5 cmd", {29'd0, cmd}, {29'd0, e.cmd});
        end
      end
      prev_valid = cmd_valid;
    end
  end

  logic [7:0] shadow_out = 8'h00;

  task automatic pulse_ack();
    cmd_ack = 1'b1;
    @(negedge clk);
    cmd_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d, input logic [1:0] ic, input bit ack_after);
    shadow_out = d;
    exp_q.push_back('{data: d, cmd: {1'b1, ic[1], ic[0]}});
    to_card = 1'b1; ic1 = ic[0]; ic2 = ic[1]; host_data_i = d; io_strobe = 1'b1;
    repeat (4) @(negedge clk);
    io_strobe = 1'b0;
    repeat (3) @(negedge clk);
    if (ack_after) pulse_ack();
  endtask

  task automatic do_read(input logic [7:0] rd, input logic [1:0] ic, input logic poll_n);
    exp_q.push_back('{data: shadow_out, cmd: {1'b0, ic[1], ic[0]}});
    to_card = 1'b0; ic1 = ic[0]; ic2 = ic[1]; int_n = poll_n;
    card_rd_data = rd; host_data_i = 8'hFF; io_strobe = 1'b1;
    repeat (3) @(negedge clk);
    if (poll_n) begin
      check(host_data_oe == 1'b1, "R6 oe during read", {31'd0, host_data_oe}, 32'd1);
      check(host_data_o == rd, "R6 read data", {24'd0, host_data_o}, {24'd0, rd});
    end else begin
      check(host_data_oe == 1'b0, "R7 oe in poll", {31'd0, host_data_oe}, 32'd0);
      check(host_data_o == 8'h00, "R7 data in poll", {24'd0, host_data_o}, 32'd0);
    end
    io_strobe = 1'b0;
    repeat (3) @(negedge clk);
    check(host_data_oe == 1'b0 && host_data_o == 8'h00, "R6 released",
          {23'd0, host_data_oe, host_data_o}, 32'd0);
    int_n = 1'b1;
    pulse_ack();
  endtask

  initial begin
    rst_n = 1'b0; sel_code = 4'hA; per_addr = 4'h3; io_strobe = 1'b0;
    to_card = 1'b0; ic1 = 1'b0; ic2 = 1'b0; int_n = 1'b1; cmd_ack = 1'b0;
    host_data_i = 8'h00; card_rd_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(flag_n && status_n, "R1 flag/status", {30'd0, flag_n, status_n}, 32'd3);
    check(out_data == 0 && cmd == 0 && !cmd_valid && !host_data_oe, "R1 registers",
          {20'd0, out_data, cmd, cmd_valid}, 32'd0);

    // R3 unselected strobe ignored
    to_card = 1'b1; ic1 = 1'b1; ic2 = 1'b1; host_data_i = 8'h55; io_strobe = 1'b1;
    repeat (4) @(negedge clk);
    io_strobe = 1'b0;
    repeat (3) @(negedge clk);
    check(flag_n && status_n, "R3 flag/status high", {30'd0, flag_n, status_n}, 32'd3);
    check(out_data == 0 && cmd == 0 && !cmd_valid, "R3 nothing captured",
          {20'd0, out_data, cmd, cmd_valid}, 32'd0);

    // R2 select
    per_addr = 4'hA;
    @(negedge clk);
    check(!flag_n && !status_n, "R2 flag/status low", {30'd0, flag_n, status_n}, 32'd0);

    // R4/R5 writes
    do_write(8'h5A, 2'b01, 1'b1);
    check(!cmd_valid, "R9 ack clears", {31'd0, cmd_valid}, 32'd0);
    do_write(8'hC3, 2'b10, 1'b1);

    // R6 read, R10 out kept; R7 poll
    do_read(8'h96, 2'b11, 1'b1);
    check(out_data == 8'hC3, "R10 out unchanged", {24'd0, out_data}, 32'hC3);
    do_read(8'h3C, 2'b00, 1'b0);

    // R8 long strobe, ack in middle
    shadow_out = 8'h81;
    exp_q.push_back('{data: 8'h81, cmd: 3'b111});
    to_card = 1'b1; ic1 = 1'b1; ic2 = 1'b1; host_data_i = 8'h81; io_strobe = 1'b1;
    repeat (4) @(negedge clk);
    check(cmd_valid, "R8 captured once", {31'd0, cmd_valid}, 32'd1);
    cmd_ack = 1'b1;
    @(negedge clk);
    cmd_ack = 1'b0;
    repeat (6) @(negedge clk);
    check(!cmd_valid, "R8 no second capture", {31'd0, cmd_valid}, 32'd0);
    io_strobe = 1'b0;
    repeat (3) @(negedge clk);

    // R9 capture wins over ack
    do_write(8'h42, 2'b01, 1'b0);
    check(cmd_valid, "R9 left pending", {31'd0, cmd_valid}, 32'd1);
    shadow_out = 8'h24;
    exp_q.push_back('{data: 8'h24, cmd: 3'b110});
    to_card = 1'b1; ic1 = 1'b0; ic2 = 1'b1; host_data_i = 8'h24;
    io_strobe = 1'b1; cmd_ack = 1'b1;
    repeat (3) @(negedge clk);
    check(cmd_valid, "R9 capture wins", {31'd0, cmd_valid}, 32'd1);
    cmd_ack = 1'b0;
    @(negedge clk);
    io_strobe = 1'b0;
    repeat (3) @(negedge clk);
    pulse_ack();
    check(!cmd_valid, "R9 cleared after ack", {31'd0, cmd_valid}, 32'd0);

    // R3 deselect
    per_addr = 4'h5;
    @(negedge clk);
    check(flag_n && status_n, "R3 deselected", {30'd0, flag_n, status_n}, 32'd3);
    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule